// File: doc/BRIEF.md
# Video status and sprite-memory read port

This block serves processor reads of two registers in a raster video unit. The first is the status register. It packs the vertical-blank, sprite-zero-hit and sprite-overflow flags into one byte. The second is the sprite attribute memory data port. The block watches the current line and dot counters, a rendering-enable flag and the three status flags. It also drives the address of an external 256-byte sprite attribute RAM and takes back that RAM's read data.

A read is a single-cycle strobe. The byte returned appears on `rd_data_o` one clock after the strobe and stays there until the next read.

A status read has side effects, all of which follow the captured byte:
- It requests a clear of the vertical-blank flag.
- It requests a reset of the shared two-write address toggle.
- If it lands early on the blanking start line, it holds off the NMI that the flag would otherwise raise.

A sprite-port read during active rendering does not see the programmed sprite address. Instead it sees the value that the evaluation hardware would be presenting at that dot.

Top module: `vsr_read_port`

## Requirements
- R1: On a status strobe, `rd_data_o` in the following cycle holds vertical blank in bit 7, sprite-zero hit in bit 6 and sprite overflow in bit 5, sampled in the strobe cycle. Bits 4..0 read as 0.
- R2: `vblank_clr_o` and `toggle_clr_o` are high for exactly the one cycle after each status strobe, and are low in every other cycle.
- R3: A status strobe on line `VBL_LINE` (241) at dot 3 or lower forces `nmi_o` low from the next cycle until `nmi_req_i` has been seen low. A status strobe at a later dot, or on another line, leaves `nmi_o` unchanged.
- R4: Apart from R3, `nmi_o` equals `nmi_req_i` delayed by one cycle.
- R5: When the line is 240 or above, or `render_en_i` is low, a sprite-port read returns the RAM byte at `spr_addr_i`.
- R6: On lines below 240 with rendering on, a sprite-port read at dots 0..63 or 256..319 returns 0xFF.
- R7: On lines below 240 with rendering on, dots 64..191 return the RAM byte at ((dot-64)*2) & 0xFC.
- R8: On lines below 240 with rendering on, dots 192..255 return the RAM byte at 0xFC on odd dots, and at ((dot-192)*2) & 0xFC on even dots.
- R9: On lines below 240 with rendering on, dots 320 and above return the RAM byte at address 0.
- R10: After reset `rd_data_o` is 0x00 and `vblank_clr_o`, `toggle_clr_o` and `nmi_o` are low. `rd_data_o` holds its value in cycles without a strobe.
- R11: When both strobes are high in the same cycle, the status byte is returned and the side effects of R2 apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dot_i | input | DOT_W | Current dot within the line |
| line_i | input | LINE_W | Current line |
| render_en_i | input | 1 | Background or sprite rendering enabled |
| vblank_i | input | 1 | Vertical-blank flag |
| spr0_hit_i | input | 1 | Sprite-zero-hit flag |
| spr_ovf_i | input | 1 | Sprite-overflow flag |
| nmi_req_i | input | 1 | NMI request from the blanking logic |
| status_rd_i | input | 1 | Status read strobe |
| spr_rd_i | input | 1 | Sprite-port read strobe |
| spr_addr_i | input | 8 | Programmed sprite RAM address |
| ram_addr_o | output | 8 | Sprite RAM read address |
| ram_data_i | input | 8 | Sprite RAM read data |
| rd_data_o | output | 8 | Returned read byte |
| vblank_clr_o | output | 1 | Clear request for the vertical-blank flag |
| toggle_clr_o | output | 1 | Reset request for the address write toggle |
| nmi_o | output | 1 | NMI line |

## Verification
A wrong dot window in the address selector returns a wrong byte on the very next read at that dot. Only a sweep over every dot finds it, so the bench reads each dot 0..340 on visible, boundary and blanking lines, with a RAM whose contents encode the address. A suppression latch that sticks, or never sets, shows on `nmi_o` one cycle after the strobe. If it sticks, the fault also shows when the request returns. A wrong pulse width on the clear outputs shows in the cycle after a status read.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int unsigned SPR_AW      = 8;
  localparam int unsigned PRE_END     = 64;   // first dot of the scan-copy window
  localparam int unsigned SCAN_END    = 192;
  localparam int unsigned EVAL_END    = 256;
  localparam int unsigned FETCH_END   = 320;
  localparam logic [7:0]  LAST_SLOT   = 8'hFC;
  localparam logic [7:0]  SLOT_MASK   = 8'hFC;
  localparam int unsigned NMI_WIN_MAX = 3;

  typedef struct packed {
    logic       vblank;
    logic       spr0_hit;
    logic       spr_ovf;
    logic [4:0] zero;
  } status_t;
endpackage

// File: rtl/vsr_spr_addr_sel.sv
module vsr_spr_addr_sel
  import vsr_pkg::*;
#(
  parameter int unsigned DOT_W     = 9,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned VIS_LINES = 240
) (
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_en_i,
  input  logic [SPR_AW-1:0] spr_addr_i,
  output logic [SPR_AW-1:0] ram_addr_o,
  output logic              force_ff_o
);
  logic             active;
  logic [DOT_W-1:0] rel;

  assign active = render_en_i && (line_i < LINE_W'(VIS_LINES));

  always_comb begin
    ram_addr_o = spr_addr_i;
    force_ff_o = 1'b0;
    rel        = '0;
    if (active) begin
      if (dot_i < DOT_W'(PRE_END)) begin
        force_ff_o = 1'b1;
      end else if (dot_i < DOT_W'(SCAN_END)) begin
        rel        = dot_i - DOT_W'(PRE_END);
        ram_addr_o = {rel[6:0], 1'b0} & SLOT_MASK;
      end else if (dot_i < DOT_W'(EVAL_END)) begin
        if (dot_i[0]) begin
          ram_addr_o = LAST_SLOT;
        end else begin
          rel        = dot_i - DOT_W'(SCAN_END);
          ram_addr_o = {rel[6:0], 1'b0} & SLOT_MASK;
        end
      end else if (dot_i < DOT_W'(FETCH_END)) begin
        force_ff_o = 1'b1;
      end else begin
        ram_addr_o = '0;
      end
    end
  end
endmodule

// File: rtl/vsr_status.sv
module vsr_status
  import vsr_pkg::*;
#(
  parameter int unsigned DOT_W    = 9,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned VBL_LINE = 241
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              status_rd_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              vblank_i,
  input  logic              spr0_hit_i,
  input  logic              spr_ovf_i,
  input  logic              nmi_req_i,
  output status_t           status_o,
  output logic              vblank_clr_o,
  output logic              toggle_clr_o,
  output logic              nmi_o
);
  logic in_win, kill_d, kill_q, clr_q, nmi_q;

  assign status_o = '{vblank: vblank_i, spr0_hit: spr0_hit_i, spr_ovf: spr_ovf_i, zero: '0};

  assign in_win = status_rd_i && (line_i == LINE_W'(VBL_LINE))
                  && (dot_i <= DOT_W'(NMI_WIN_MAX));
  // suppression persists until the request has dropped once
  assign kill_d = in_win || (kill_q && nmi_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kill_q <= 1'b0;
      clr_q  <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      kill_q <= kill_d;
      clr_q  <= status_rd_i;
      nmi_q  <= nmi_req_i && !kill_d;
    end
  end

  assign vblank_clr_o = clr_q;
  assign toggle_clr_o = clr_q;
  assign nmi_o        = nmi_q;

  AST_CLR_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> (vblank_clr_o && toggle_clr_o)); // R2
  AST_NO_SPURIOUS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_rd_i |=> !vblank_clr_o); // R2
  AST_NMI_SUPPRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |=> !nmi_o); // R3
  AST_NMI_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_req_i |=> !nmi_o); // R4
endmodule

// File: rtl/vsr_read_port.sv
module vsr_read_port
  import vsr_pkg::*;
#(
  parameter int unsigned DOT_W     = 9,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned VIS_LINES = 240,
  parameter int unsigned VBL_LINE  = 241
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_en_i,
  input  logic              vblank_i,
  input  logic              spr0_hit_i,
  input  logic              spr_ovf_i,
  input  logic              nmi_req_i,
  input  logic              status_rd_i,
  input  logic              spr_rd_i,
  input  logic [7:0]        spr_addr_i,
  output logic [7:0]        ram_addr_o,
  input  logic [7:0]        ram_data_i,
  output logic [7:0]        rd_data_o,
  output logic              vblank_clr_o,
  output logic              toggle_clr_o,
  output logic              nmi_o
);
  status_t    status;
  logic       force_ff;
  logic [7:0] rd_q;

  vsr_spr_addr_sel #(.DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES)) u_addr (
    .dot_i       (dot_i),
    .line_i      (line_i),
    .render_en_i (render_en_i),
    .spr_addr_i  (spr_addr_i),
    .ram_addr_o  (ram_addr_o),
    .force_ff_o  (force_ff)
  );

  vsr_status #(.DOT_W(DOT_W), .LINE_W(LINE_W), .VBL_LINE(VBL_LINE)) u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .status_rd_i  (status_rd_i),
    .dot_i        (dot_i),
    .line_i       (line_i),
    .vblank_i     (vblank_i),
    .spr0_hit_i   (spr0_hit_i),
    .spr_ovf_i    (spr_ovf_i),
    .nmi_req_i    (nmi_req_i),
    .status_o     (status),
    .vblank_clr_o (vblank_clr_o),
    .toggle_clr_o (toggle_clr_o),
    .nmi_o        (nmi_o)
  );

  // status wins when both strobes coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rd_q <= '0;
    else if (status_rd_i) rd_q <= status;
    else if (spr_rd_i)    rd_q <= force_ff ? 8'hFF : ram_data_i;
  end

  assign rd_data_o = rd_q;

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> (rd_data_o[4:0] == 5'd0)); // R1
  AST_STATUS_VBL_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> (rd_data_o[7] == $past(vblank_i))); // R1
  AST_FORCED_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_rd_i && !status_rd_i && force_ff) |=> (rd_data_o == 8'hFF)); // R6
  AST_SPR_FROM_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_rd_i && !status_rd_i && !force_ff) |=> (rd_data_o == $past(ram_data_i))); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spr_rd_i && !status_rd_i) |=> $stable(rd_data_o)); // R10
endmodule

// File: tb/vsr_read_port_test.sv
module vsr_read_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] dot = '0, line = '0;
  logic       ren = 1'b0, vbl = 1'b0, hit = 1'b0, ovf = 1'b0, nreq = 1'b0;
  logic       srd = 1'b0, prd = 1'b0;
  logic [7:0] saddr = '0;
  logic [7:0] raddr, rdata, rd;
  logic       vclr, tclr, nmi;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign rdata = raddr ^ 8'h5A;  // RAM model: contents encode the address

  vsr_read_port uut (
    .clk_i(clk), .rst_ni(rst_n), .dot_i(dot), .line_i(line), .render_en_i(ren),
    .vblank_i(vbl), .spr0_hit_i(hit), .spr_ovf_i(ovf), .nmi_req_i(nreq),
    .status_rd_i(srd), .spr_rd_i(prd), .spr_addr_i(saddr), .ram_addr_o(raddr),
    .ram_data_i(rdata), .rd_data_o(rd), .vblank_clr_o(vclr), .toggle_clr_o(tclr),
    .nmi_o(nmi)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ram_of(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  function automatic logic [7:0] exp_spr(input int ln, input int d, input bit r, input logic [7:0] sa);
    if (!r || ln >= 240) return ram_of(sa);
    if (d < 64 || (d >= 256 && d < 320)) return 8'hFF;
    if (d < 192) return ram_of(8'((d - 64) * 2) & 8'hFC);
    if (d < 256) return (d % 2 == 1) ? ram_of(8'hFC) : ram_of(8'((d - 192) * 2) & 8'hFC);
    return ram_of(8'h00);
  endfunction

  function automatic string req_of(input int ln, input int d, input bit r);
    if (!r || ln >= 240) return "R5";
    if (d < 64 || (d >= 256 && d < 320)) return "R6";
    if (d < 192) return "R7";
    if (d < 256) return "R8";
    return "R9";
  endfunction

  task automatic pulse_read(input bit s, input bit p);
    @(negedge clk);
    srd = s; prd = p;
    @(negedge clk);
    srd = 1'b0; prd = 1'b0;
  endtask

  task automatic t_reset;
    chk(rd == 8'h00, "R10 reset rd", rd, 8'h00);
    chk(!vclr && !tclr, "R10 reset clr", {6'd0, vclr, tclr}, 8'h00);
    chk(!nmi, "R10 reset nmi", {7'd0, nmi}, 8'h00);
  endtask

  task automatic t_status;
    line = 9'd10; dot = 9'd100;
    vbl = 1; hit = 0; ovf = 1;
    pulse_read(1, 0);
    chk(rd == 8'hA0, "R1 status byte", rd, 8'hA0);
    chk(vclr && tclr, "R2 clear pulse", {6'd0, vclr, tclr}, 8'h03);
    vbl = 0; hit = 1; ovf = 0;
    @(negedge clk);
    chk(!vclr && !tclr, "R2 pulse one cycle", {6'd0, vclr, tclr}, 8'h00);
    chk(rd == 8'hA0, "R10 hold", rd, 8'hA0);
    pulse_read(1, 0);
    chk(rd == 8'h40, "R1 status byte hit", rd, 8'h40);
    vbl = 1; hit = 1; ovf = 1; saddr = 8'h11; ren = 0;
    pulse_read(1, 1);
    chk(rd == 8'hE0, "R11 both strobes", rd, 8'hE0);
    chk(vclr, "R11 clear on both", {7'd0, vclr}, 8'h01);
    vbl = 0; hit = 0; ovf = 0;
  endtask

  task automatic t_nmi;
    nreq = 1; line = 9'd241; dot = 9'd0;
    @(negedge clk);
    chk(nmi, "R4 nmi follows", {7'd0, nmi}, 8'h01);
    dot = 9'd1;
    pulse_read(1, 0);
    chk(!nmi, "R3 suppressed", {7'd0, nmi}, 8'h00);
    @(negedge clk);
    chk(!nmi, "R3 suppression held", {7'd0, nmi}, 8'h00);
    nreq = 0;
    @(negedge clk);
    chk(!nmi, "R4 req low", {7'd0, nmi}, 8'h00);
    nreq = 1;
    @(negedge clk);
    chk(nmi, "R3 suppression released", {7'd0, nmi}, 8'h01);
    dot = 9'd3;
    pulse_read(1, 0);
    chk(!nmi, "R3 dot 3 edge", {7'd0, nmi}, 8'h00);
    nreq = 0; @(negedge clk); nreq = 1; @(negedge clk);
    dot = 9'd4;
    pulse_read(1, 0);
    chk(nmi, "R3 dot 4 no effect", {7'd0, nmi}, 8'h01);
    line = 9'd240; dot = 9'd1;
    pulse_read(1, 0);
    chk(nmi, "R3 other line no effect", {7'd0, nmi}, 8'h01);
    nreq = 0;
    @(negedge clk);
  endtask

  task automatic sweep(input int ln, input bit r);
    ren = r; line = 9'(ln);
    for (int d = 0; d <= 340; d++) begin
      dot = 9'(d);
      saddr = 8'(d) ^ 8'h33;
      pulse_read(0, 1);
      chk(rd == exp_spr(ln, d, r, saddr), req_of(ln, d, r), rd, exp_spr(ln, d, r, saddr));
    end
  endtask

  task automatic t_sprite;
    sweep(0, 1);
    sweep(120, 1);
    sweep(239, 1);
    sweep(240, 1);
    sweep(261, 1);
    sweep(0, 0);
    @(negedge clk);
    chk(!vclr, "R2 no pulse on sprite read", {7'd0, vclr}, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_status();
    t_nmi();
    t_sprite();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule